// File: doc/BRIEF.md
# Dual-Channel Registered Thermometer Drive-Strength Decoder

This block sits between a waveform sequencer and a segmented gate-drive array of parallel transistors. The sequencer supplies two unsigned binary strength codes on every drive-clock period: one for the pull-up segment array and one for the pull-down segment array. The block expands each code into a thermometer enable vector whose number of set bits equals the code value. The set bits always run from bit 0 upwards without a gap.

Both codes are sampled on the same rising clock edge, and both enable vectors come straight from flip-flops. A multi-bit code step, such as 31 to 32, therefore reaches the driver segments as one clean change on a single edge. With a purely combinational decode, unequal bit skew could briefly switch on every segment. A load-enable input freezes the captured strengths between updates, and a synchronous reset switches every segment off. The block does not check whether the pull-up and pull-down drives overlap; that check belongs to the sequencer.

Top module: `drive_thermo_latch`

## Requirements
- R1: With rst high at a rising edge, all bits of up_en and dn_en are 0 after that edge, whatever the other inputs are.
- R2: After a capture of code k on a channel, that channel's enable bits 0 through k-1 are 1 and bits k through 62 are 0, so code 0 gives all zeros and code 63 gives all 63 bits set.
- R3: When load is high and rst is low at a rising edge, both up_code and dn_code are captured on that same edge, and both enable vectors reflect them right after it.
- R4: When load is low and rst is low at a rising edge, up_en and dn_en keep their previous values, whatever the code inputs are.
- R5: Across any code change, including 31 to 32, 32 to 31 and 0 to 63, the number of set enables seen between edges is only the old count or the new code, never a value between or beyond them.
- R6: The two channels are independent: each vector depends only on its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Drive clock; all updates happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears both enable vectors |
| load | input | 1 | When high, captures both codes on the edge |
| up_code | input | CODE_W | Binary pull-up strength, number of active pull-up segments |
| dn_code | input | CODE_W | Binary pull-down strength, number of active pull-down segments |
| up_en | output | 2**CODE_W-1 | Registered thermometer enables for the pull-up segments |
| dn_en | output | 2**CODE_W-1 | Registered thermometer enables for the pull-down segments |

## Verification
The only state is the two registered enable vectors. A corrupted bit shows on the ports right after the edge that loads it, as a wrong count or as a gap in the run of ones. A fault in the hold path shows one edge after load drops, when new codes on the inputs leak through. The sweep walks every adjacent code pair in both directions on both channels, with the two channels moving in opposite directions. It also applies random jumps, holds and a reset in the middle of a run, and compares every vector bit-for-bit against the arithmetic value (2**k)-1.

// File: rtl/drive_thermo_latch.sv
module drive_thermo_latch #(
  parameter int CODE_W = 6,
  localparam int SEG_N = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] up_code,
  input  logic [CODE_W-1:0] dn_code,
  output logic [SEG_N-1:0]  up_en,
  output logic [SEG_N-1:0]  dn_en
);

  logic [SEG_N-1:0] up_nxt;
  logic [SEG_N-1:0] dn_nxt;

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign up_nxt[i] = up_code > CODE_W'(i);
    assign dn_nxt[i] = dn_code > CODE_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_en <= '0;
      dn_en <= '0;
    end else if (load) begin
      up_en <= up_nxt;
      dn_en <= dn_nxt;
    end
  end

endmodule

// File: rtl/drive_thermo_latch_chk.sv
module drive_thermo_latch_chk #(
  parameter int CODE_W = 6,
  localparam int SEG_N = (1 << CODE_W) - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [CODE_W-1:0] up_code,
  input logic [CODE_W-1:0] dn_code,
  input logic [SEG_N-1:0]  up_en,
  input logic [SEG_N-1:0]  dn_en
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (up_en == '0) && (dn_en == '0));

  a_r2_up_contiguous: assert property (@(posedge clk) disable iff (rst)
    ((up_en + SEG_N'(1)) & up_en) == '0);

  a_r2_dn_contiguous: assert property (@(posedge clk) disable iff (rst)
    ((dn_en + SEG_N'(1)) & dn_en) == '0);

  a_r3_capture_count: assert property (@(posedge clk) disable iff (rst)
    load |=> ($countones(up_en) == int'($past(up_code))) &&
             ($countones(dn_en) == int'($past(dn_code))));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(up_en) && $stable(dn_en));

  a_r5_no_intermediate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($countones(up_en) == $countones($past(up_en))) ||
              ($countones(up_en) == int'($past(up_code)))) &&
             (($countones(dn_en) == $countones($past(dn_en))) ||
              ($countones(dn_en) == int'($past(dn_code)))));

endmodule

bind drive_thermo_latch drive_thermo_latch_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/drive_thermo_latch_tb.sv
module drive_thermo_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 6;
  localparam int SEG_N = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [CODE_W-1:0] up_code = '0;
  logic [CODE_W-1:0] dn_code = '0;
  logic [SEG_N-1:0] up_en;
  logic [SEG_N-1:0] dn_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [SEG_N-1:0] up_exp = '0;
  logic [SEG_N-1:0] dn_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drive_thermo_latch #(.CODE_W(CODE_W)) u_dut (
    .clk(clk), .rst(rst), .load(load),
    .up_code(up_code), .dn_code(dn_code),
    .up_en(up_en), .dn_en(dn_en)
  );

  function automatic logic [SEG_N-1:0] therm(input int k);
    logic [SEG_N:0] t;
    t = ({{SEG_N{1'b0}}, 1'b1} << k) - 1'b1;
    return t[SEG_N-1:0];
  endfunction

  task automatic check(input string req);
    checks++;
    if (up_en !== up_exp) begin
      errors++;
      $display("FAIL %s up_en actual=%h expected=%h", req, up_en, up_exp);
    end
    checks++;
    if (dn_en !== dn_exp) begin
      errors++;
      $display("FAIL %s dn_en actual=%h expected=%h", req, dn_en, dn_exp);
    end
  endtask

  task automatic step(input bit r, input bit l, input int u, input int d, input string req);
    @(negedge clk);
    rst = r;
    load = l;
    up_code = CODE_W'(u);
    dn_code = CODE_W'(d);
    @(posedge clk);
    #1;
    if (r) begin
      up_exp = '0;
      dn_exp = '0;
    end else if (l) begin
      up_exp = therm(u);
      dn_exp = therm(d);
    end
    check(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    step(1, 1, 63, 63, "R1 reset state");
    step(0, 1, 0, 63, "R2 code 0 and 63");
    step(0, 1, 63, 0, "R6 channels swapped");
    for (int k = 0; k <= SEG_N; k++)
      step(0, 1, k, SEG_N - k, "R2 R5 ascending sweep");
    for (int k = SEG_N; k >= 0; k--)
      step(0, 1, k, SEG_N - k, "R2 R5 descending sweep");
    step(0, 1, 31, 32, "R5 mid setup");
    step(0, 1, 32, 31, "R5 31 to 32 step");
    step(0, 1, 31, 32, "R5 32 to 31 step");
    step(0, 0, 5, 60, "R4 hold");
    step(0, 0, 0, 0, "R4 hold second cycle");
    step(0, 1, 7, 7, "R3 capture both");
    step(0, 1, 7, 40, "R6 only down changes");
    for (int n = 0; n < 300; n++) begin
      int u;
      int d;
      u = int'($urandom % 64);
      d = int'($urandom % 64);
      step(0, ($urandom % 4) != 0, u, d, "R3 R4 random jumps");
    end
    step(0, 1, 50, 12, "R3 before reset");
    step(1, 0, 50, 12, "R1 reset mid run");
    step(0, 0, 20, 20, "R4 hold after reset");
    step(0, 1, 20, 21, "R3 after reset");
    finish_run();
  end
endmodule